// File: doc/BRIEF.md
# Banked DMA Destination Address Generator

This block produces the 32-bit destination address for a single DMA channel. Only the low half of the address is held in a working register. The high half is not stored there. It is taken from one of three fixed memory regions, picked by a 2-bit bank select. Software programs a start value through a halfword-wide write port and can read the live value back at any time.

A mode input chooses how the address behaves across transfers. In hold mode the address stays put. In advance mode it moves forward after every completed transfer, by one for byte transfers and by two for halfword transfers. Advancing wraps inside the selected bank and never carries into the high half. An external transfer counter signals each completed transfer with a one-cycle strobe. The register uses a big-endian bit numbering: bit 0 of the register holds the most significant bit of the low address half.

Top module: `dma_bank_addr_gen`

## Requirements
- R1: A cycle with `wrEn` high loads the low half from `wrData`. The new value shows on `addr` and `rdData` in the following cycle.
- R2: Register bit k maps to low-address bit 15-k. A write of 16'h0001 gives `addr[15:0]` = 16'h8000, and a write of 16'h8000 gives 16'h0001.
- R3: With `incMode` low (hold mode), `xferDone` leaves `addr` and `rdData` unchanged.
- R4: With `incMode` high and `wideXfer` low, each `xferDone` adds 1 to `addr[15:0]` in the next cycle.
- R5: With `incMode` high and `wideXfer` high, each `xferDone` adds 2 to `addr[15:0]` in the next cycle.
- R6: Advancing wraps modulo 2^16 inside the bank and leaves `addr[31:16]` unchanged. 16'hFFFF+1 gives 16'h0000, 16'hFFFE+2 gives 16'h0000, and 16'hFFFF+2 gives 16'h0001.
- R7: `addr[31:16]` equals the bank base chosen by `bankSel` in the previous cycle. The defaults are 16'h0080 for 0, 16'h0081 for 1 and 16'h0082 for 2. After reset the high half is the bank 0 base.
- R8: `bankSel` = 3 is reserved. It sets `bankErr` in the next cycle and suppresses advancing, and the whole of `addr` keeps its value. `bankErr` is low after reset and whenever the previous `bankSel` was 0 to 2.
- R9: When `wrEn` and `xferDone` arrive in the same cycle, the write wins and no step is added.
- R10: `rdData` always returns the current working address in register bit order, including after advancing. It never returns the originally programmed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Halfword register write strobe |
| wrData | input | 16 | Write data, register bit order |
| incMode | input | 1 | 1 = advance after each transfer, 0 = hold |
| wideXfer | input | 1 | 1 = halfword transfer (step 2), 0 = byte (step 1) |
| bankSel | input | 2 | Bank select; 3 is reserved |
| xferDone | input | 1 | One-cycle transfer-complete strobe |
| rdData | output | 16 | Current low address, register bit order |
| addr | output | 32 | Bank high half concatenated with current low half |
| bankErr | output | 1 | Reserved bank select seen in previous cycle |

## Verification
A register write and a transfer-complete strobe can land in the same cycle. The vector walk provokes this by raising `wrEn` and `xferDone` together, once in advance mode with the wide step and once in hold mode. The result is judged correct only if the next-cycle address equals the written value with no step added. A second collision, a strobe that arrives while the reserved bank is selected, is judged by requiring that `addr` stay unchanged and that `bankErr` rise.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  typedef struct packed {
    logic load;     // take write data
    logic advance;  // add the step
    logic stepTwo;  // step is 2 instead of 1
    logic bankBad;  // reserved bank select
  } addrStrobes_t;
endpackage

// File: rtl/dma_addr_ctrl.sv
module dma_addr_ctrl
  import dma_addr_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int BANKS = 3
) (
  input  logic             wrEn,
  input  logic             incMode,
  input  logic             wideXfer,
  input  logic             xferDone,
  input  logic [SEL_W-1:0] bankSel,
  output addrStrobes_t     strobes
);
  logic selReserved;

  always_comb begin
    selReserved     = (int'(bankSel) >= BANKS);
    strobes.load    = wrEn;
    strobes.bankBad = selReserved;
    strobes.stepTwo = wideXfer;
    // a write has priority over stepping; reserved bank freezes stepping
    strobes.advance = xferDone && incMode && !selReserved && !wrEn;
  end
endmodule

// File: rtl/dma_addr_dp.sv
module dma_addr_dp
  import dma_addr_pkg::*;
#(
  parameter int LOW_W = 16,
  parameter int HI_W  = 16,
  parameter int SEL_W = 2,
  parameter int BANKS = 3,
  parameter logic [HI_W-1:0] BANK0_HI = 16'h0080,
  parameter logic [HI_W-1:0] BANK1_HI = 16'h0081,
  parameter logic [HI_W-1:0] BANK2_HI = 16'h0082
) (
  input  logic             clk,
  input  logic             rstN,
  input  addrStrobes_t     strobes,
  input  logic [LOW_W-1:0] wrData,
  input  logic [SEL_W-1:0] bankSel,
  output logic [LOW_W-1:0] lowAddr,
  output logic [HI_W-1:0]  bankHi,
  output logic [LOW_W-1:0] rdData,
  output logic             bankErr
);
  localparam logic [LOW_W-1:0] STEP_ONE = LOW_W'(1);
  localparam logic [LOW_W-1:0] STEP_TWO = LOW_W'(2);
  localparam logic [HI_W-1:0] BASES [BANKS] = '{BANK0_HI, BANK1_HI, BANK2_HI};

  logic [LOW_W-1:0] wrSwapped;
  logic [LOW_W-1:0] stepVal;
  logic [LOW_W-1:0] nextLow;
  logic [HI_W-1:0]  selBase;

  // register bit k is address bit LOW_W-1-k
  for (genvar k = 0; k < LOW_W; k++) begin : g_swap
    assign wrSwapped[k] = wrData[LOW_W-1-k];
    assign rdData[k]    = lowAddr[LOW_W-1-k];
  end

  always_comb begin
    stepVal = strobes.stepTwo ? STEP_TWO : STEP_ONE;
    nextLow = lowAddr;
    if (strobes.load)         nextLow = wrSwapped;
    else if (strobes.advance) nextLow = lowAddr + stepVal; // wraps in bank
    selBase = bankHi;
    for (int b = 0; b < BANKS; b++)
      if (int'(bankSel) == b) selBase = BASES[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowAddr <= '0;
      bankHi  <= BANK0_HI;
      bankErr <= 1'b0;
    end else begin
      lowAddr <= nextLow;
      bankErr <= strobes.bankBad;
      if (!strobes.bankBad) bankHi <= selBase;
    end
  end
endmodule

// File: rtl/dma_bank_addr_gen.sv
module dma_bank_addr_gen
  import dma_addr_pkg::*;
#(
  parameter int LOW_W = 16,
  parameter int HI_W  = 16,
  parameter int SEL_W = 2,
  parameter int BANKS = 3,
  parameter logic [HI_W-1:0] BANK0_HI = 16'h0080,
  parameter logic [HI_W-1:0] BANK1_HI = 16'h0081,
  parameter logic [HI_W-1:0] BANK2_HI = 16'h0082
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [LOW_W-1:0]      wrData,
  input  logic                  incMode,
  input  logic                  wideXfer,
  input  logic [SEL_W-1:0]      bankSel,
  input  logic                  xferDone,
  output logic [LOW_W-1:0]      rdData,
  output logic [HI_W+LOW_W-1:0] addr,
  output logic                  bankErr
);
  addrStrobes_t     strobes;
  logic [LOW_W-1:0] lowAddr;
  logic [HI_W-1:0]  bankHi;

  dma_addr_ctrl #(.SEL_W(SEL_W), .BANKS(BANKS)) u_ctrl (
    .wrEn(wrEn), .incMode(incMode), .wideXfer(wideXfer),
    .xferDone(xferDone), .bankSel(bankSel), .strobes(strobes)
  );

  dma_addr_dp #(
    .LOW_W(LOW_W), .HI_W(HI_W), .SEL_W(SEL_W), .BANKS(BANKS),
    .BANK0_HI(BANK0_HI), .BANK1_HI(BANK1_HI), .BANK2_HI(BANK2_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .bankSel(bankSel), .lowAddr(lowAddr), .bankHi(bankHi),
    .rdData(rdData), .bankErr(bankErr)
  );

  assign addr = {bankHi, lowAddr};
endmodule

// File: rtl/dma_bank_addr_gen_chk.sv
module dma_bank_addr_gen_chk #(
  parameter int LOW_W = 16,
  parameter int HI_W  = 16,
  parameter int SEL_W = 2,
  parameter logic [HI_W-1:0] BANK0_HI = 16'h0080,
  parameter logic [HI_W-1:0] BANK1_HI = 16'h0081,
  parameter logic [HI_W-1:0] BANK2_HI = 16'h0082
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [LOW_W-1:0]      wrData,
  input logic                  incMode,
  input logic                  wideXfer,
  input logic [SEL_W-1:0]      bankSel,
  input logic                  xferDone,
  input logic [LOW_W-1:0]      rdData,
  input logic [HI_W+LOW_W-1:0] addr,
  input logic                  bankErr
);
  logic [HI_W-1:0] expBase;
  always_comb begin
    case (bankSel)
      2'd0:    expBase = BANK0_HI;
      2'd1:    expBase = BANK1_HI;
      default: expBase = BANK2_HI;
    endcase
  end

  p_write_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == $past(wrData));

  p_hold_mode_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !incMode && bankSel != 2'd3) |=> $stable(rdData));

  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && incMode && xferDone && !wideXfer && bankSel != 2'd3)
      |=> addr[LOW_W-1:0] == $past(addr[LOW_W-1:0]) + LOW_W'(1));

  p_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && incMode && xferDone && wideXfer && bankSel != 2'd3)
      |=> addr[LOW_W-1:0] == $past(addr[LOW_W-1:0]) + LOW_W'(2));

  p_bank_hi_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bankSel != 2'd3) |=> (addr[HI_W+LOW_W-1:LOW_W] == $past(expBase)) && !bankErr);

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bankSel == 2'd3 && !wrEn) |=> $stable(addr) && bankErr);
endmodule

bind dma_bank_addr_gen dma_bank_addr_gen_chk #(
  .LOW_W(LOW_W), .HI_W(HI_W), .SEL_W(SEL_W),
  .BANK0_HI(BANK0_HI), .BANK1_HI(BANK1_HI), .BANK2_HI(BANK2_HI)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .incMode(incMode),
  .wideXfer(wideXfer), .bankSel(bankSel), .xferDone(xferDone),
  .rdData(rdData), .addr(addr), .bankErr(bankErr)
);

// File: tb/dma_bank_addr_gen_tb.sv
`timescale 1ns/1ps
module dma_bank_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        incMode = 1'b0;
  logic        wideXfer = 1'b0;
  logic [1:0]  bankSel = '0;
  logic        xferDone = 1'b0;
  logic [15:0] rdData;
  logic [31:0] addr;
  logic        bankErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_bank_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .incMode(incMode),
    .wideXfer(wideXfer), .bankSel(bankSel), .xferDone(xferDone),
    .rdData(rdData), .addr(addr), .bankErr(bankErr)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] low;     // desired low address (address bit order)
    logic        inc;
    logic        wide;
    logic [1:0]  bank;
    logic        done;
    logic [31:0] expAddr;
    logic        expErr;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h1234, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0080_1234, 1'b0}, // R1
    '{1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b1, 32'h0080_1234, 1'b0}, // R3
    '{1'b0, 16'h0000, 1'b1, 1'b0, 2'd0, 1'b1, 32'h0080_1235, 1'b0}, // R4
    '{1'b0, 16'h0000, 1'b1, 1'b1, 2'd0, 1'b1, 32'h0080_1237, 1'b0}, // R5
    '{1'b0, 16'h0000, 1'b1, 1'b1, 2'd0, 1'b0, 32'h0080_1237, 1'b0}, // R10
    '{1'b0, 16'h0000, 1'b1, 1'b0, 2'd1, 1'b0, 32'h0081_1237, 1'b0}, // R7
    '{1'b0, 16'h0000, 1'b1, 1'b1, 2'd2, 1'b1, 32'h0082_1239, 1'b0}, // R7
    '{1'b1, 16'hFFFF, 1'b1, 1'b0, 2'd2, 1'b0, 32'h0082_FFFF, 1'b0}, // R1
    '{1'b0, 16'h0000, 1'b1, 1'b0, 2'd2, 1'b1, 32'h0082_0000, 1'b0}, // R6
    '{1'b1, 16'hFFFE, 1'b1, 1'b1, 2'd2, 1'b0, 32'h0082_FFFE, 1'b0}, // R1
    '{1'b0, 16'h0000, 1'b1, 1'b1, 2'd2, 1'b1, 32'h0082_0000, 1'b0}, // R6
    '{1'b1, 16'hFFFF, 1'b1, 1'b1, 2'd2, 1'b0, 32'h0082_FFFF, 1'b0}, // R1
    '{1'b0, 16'h0000, 1'b1, 1'b1, 2'd2, 1'b1, 32'h0082_0001, 1'b0}, // R6
    '{1'b0, 16'h0000, 1'b1, 1'b1, 2'd3, 1'b1, 32'h0082_0001, 1'b1}, // R8
    '{1'b0, 16'h0000, 1'b1, 1'b0, 2'd3, 1'b1, 32'h0082_0001, 1'b1}, // R8
    '{1'b0, 16'h0000, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0080_0001, 1'b0}, // R8
    '{1'b1, 16'h5555, 1'b1, 1'b1, 2'd0, 1'b1, 32'h0080_5555, 1'b0}, // R9
    '{1'b1, 16'hAAAA, 1'b0, 1'b0, 2'd0, 1'b1, 32'h0080_AAAA, 1'b0}  // R9
  };

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: bank 0 high half, no error (low half not checked)
    check("R7 reset high half", {16'h0, addr[31:16]}, 32'h0080);
    check("R8 reset bankErr", {31'h0, bankErr}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      wrEn     = VECS[v].wr;
      wrData   = rev16(VECS[v].low);
      incMode  = VECS[v].inc;
      wideXfer = VECS[v].wide;
      bankSel  = VECS[v].bank;
      xferDone = VECS[v].done;
      @(negedge clk);
      check($sformatf("R1-vector %0d addr", v), addr, VECS[v].expAddr);
      check($sformatf("R8 vector %0d bankErr", v), {31'h0, bankErr}, {31'h0, VECS[v].expErr});
      check($sformatf("R10 vector %0d rdData", v), {16'h0, rdData},
            {16'h0, rev16(VECS[v].expAddr[15:0])});
    end

    // R2: raw bit order
    wrEn = 1'b1; wrData = 16'h0001; xferDone = 1'b0; incMode = 1'b0; bankSel = 2'd0;
    @(negedge clk);
    check("R2 write 0001 addr low", {16'h0, addr[15:0]}, 32'h8000);
    check("R2 write 0001 readback", {16'h0, rdData}, 32'h0001);
    wrData = 16'h8000;
    @(negedge clk);
    check("R2 write 8000 addr low", {16'h0, addr[15:0]}, 32'h0001);
    wrEn = 1'b0; incMode = 1'b1; wideXfer = 1'b1; xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    check("R10 readback after step", {16'h0, rdData}, {16'h0, rev16(16'h0003)});
    @(negedge clk);
    check("R3 no strobe holds", addr, 32'h0080_0003);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule